// File: doc/BRIEF.md
# Thermal Override and Interrupt Controller

This block sits between a hardware monitor's fan-control logic and one bidirectional, active-low thermal alarm pad. In alarm mode the pad is open-drain. The block pulls the pad low whenever the internal over-limit comparator result is true. It also watches the pad level, so a low level forced from outside the chip drives every fan PWM duty value and every analog DAC code to full scale. That forcing lasts as long as the pad stays low.

One configuration bit moves the pad into general-purpose I/O mode. In that mode the pad's direction and driven value come from GPIO register inputs, and a low pad level no longer forces the fans. Any thermal event sets a sticky interrupt. The interrupt is cleared by any of three one-cycle strobes: a read of the first status register, a write that sets the interrupt-clear configuration bit, or an alert-response cycle on the management bus.

Top module: `therm_ovr_ctrl`

## Requirements
- R1: With `cfg_gpio_mode` = 0 (alarm mode), `pad_out` is 0 and `pad_oe` equals `over_limit` in the same cycle.
- R2: With `cfg_gpio_mode` = 1 (GPIO mode), `pad_oe` equals `gpio_dir` and `pad_out` equals `gpio_out`, and `over_limit` does not drive the pad.
- R3: In alarm mode, when `pad_in` has been sampled low on two consecutive rising edges, every PWM field and every DAC field of the outputs is all ones. The first forced output is visible after the second of those edges.
- R4: In alarm mode, once `pad_in` returns high, the forced values stay on the outputs until the second rising edge after the return. After that edge, `pwm_out` equals `pwm_in` and `dac_out` equals `dac_in`.
- R5: In GPIO mode, a low `pad_in` forces no output and raises no interrupt: `pwm_out` = `pwm_in`, `dac_out` = `dac_in`.
- R6: A thermal event is defined as `over_limit` = 1, or a synchronized low pad level while in alarm mode. A thermal event in a cycle with no clear strobe sets `irq` after the next rising edge.
- R7: Once set, `irq` stays at 1 after the event ends, until a clear strobe arrives.
- R8: Each of `clr_status_rd`, `clr_cfg_set` and `clr_alert_resp`, held for one cycle, sets `irq` to 0 after the next rising edge.
- R9: A clear strobe takes priority over an event in the same cycle. If the event persists, `irq` is 0 for exactly one cycle and then returns to 1.
- R10: During and right after reset, `irq` is 0 and the synchronized pad level reads high. No output is forced and `gpio_in` = 1, whatever the level on `pad_in`.
- R11: `gpio_in` shows the level of `pad_in` delayed by two rising edges, in either mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pad_in | input | 1 | Level seen at the thermal alarm pad |
| pad_oe | output | 1 | Pad output enable |
| pad_out | output | 1 | Value driven on the pad while enabled |
| over_limit | input | 1 | Temperature comparator result, 1 = over limit |
| cfg_gpio_mode | input | 1 | 1 = pad is GPIO, 0 = pad is thermal alarm |
| gpio_dir | input | 1 | GPIO direction, 1 = drive |
| gpio_out | input | 1 | GPIO drive value |
| gpio_in | output | 1 | Synchronized pad level |
| clr_status_rd | input | 1 | Strobe: first status register read |
| clr_cfg_set | input | 1 | Strobe: interrupt-clear config bit written to 1 |
| clr_alert_resp | input | 1 | Strobe: alert-response cycle completed |
| irq | output | 1 | Sticky thermal interrupt, active high |
| pwm_in | input | PWM_CH*PWM_W | Normal fan PWM duty values |
| pwm_out | output | PWM_CH*PWM_W | PWM duty values after override |
| dac_in | input | DAC_CH*DAC_W | Normal fan DAC codes |
| dac_out | output | DAC_CH*DAC_W | DAC codes after override |

## Verification
The pad path is exercised with each combination of mode, external pad level, comparator result and GPIO direction/value. The combinations separate three cases: a low driven from outside, a low the block drives itself, and a low a GPIO write drives, since only the first two may force the fans. Override entry and exit are sampled one and two edges after each pad change, which exposes a synchronizer of the wrong depth. Each clear source is pulsed both after the event has gone and while it persists. This tells a clear that never works apart from one that fails to lose against a lasting event.

// File: rtl/therm_ovr_pkg.sv
package therm_ovr_pkg;

  typedef enum logic {
    ROLE_ALARM = 1'b0,
    ROLE_GPIO  = 1'b1
  } pin_role_e;

  typedef struct packed {
    logic oe;
    logic val;
  } pad_drv_t;

  // Open-drain alarm drive, or GPIO register drive.
  function automatic pad_drv_t pad_drive(input pin_role_e role, input logic ovl,
                                         input logic dir, input logic gout);
    pad_drv_t d;
    if (role == ROLE_GPIO) begin
      d.oe  = dir;
      d.val = gout;
    end else begin
      d.oe  = ovl;
      d.val = 1'b0;
    end
    return d;
  endfunction

  // Sticky latch update: a clear beats a same-cycle event.
  function automatic logic irq_next(input logic cur, input logic evt, input logic clr);
    return clr ? 1'b0 : (cur | evt);
  endfunction

endpackage

// File: rtl/therm_sync.sv
module therm_sync #(
  parameter int  STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= {STAGES{RESET_VAL}};
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/therm_irq.sv
module therm_irq
  import therm_ovr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic evt,
  input  logic clr_status_rd,
  input  logic clr_cfg_set,
  input  logic clr_alert_resp,
  output logic irq
);
  logic any_clr;
  logic irq_q;

  assign any_clr = clr_status_rd | clr_cfg_set | clr_alert_resp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_next(irq_q, evt, any_clr);
  end

  assign irq = irq_q;

  a_r6_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && !any_clr) |=> irq);
  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !any_clr) |=> irq);
  a_r8_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_status_rd || clr_cfg_set || clr_alert_resp) |=> !irq);
  a_r9_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (any_clr && evt) |=> !irq);
endmodule

// File: rtl/therm_force.sv
module therm_force #(
  parameter int CH = 2,
  parameter int W  = 8
) (
  input  logic          force_max,
  input  logic [CH*W-1:0] din,
  output logic [CH*W-1:0] dout
);
  for (genvar c = 0; c < CH; c++) begin : g_ch
    assign dout[c*W +: W] = force_max ? {W{1'b1}} : din[c*W +: W];
  end
endmodule

// File: rtl/therm_ovr_ctrl.sv
module therm_ovr_ctrl
  import therm_ovr_pkg::*;
#(
  parameter int PWM_CH   = 2,
  parameter int PWM_W    = 8,
  parameter int DAC_CH   = 1,
  parameter int DAC_W    = 8,
  parameter int SYNC_STG = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     pad_in,
  output logic                     pad_oe,
  output logic                     pad_out,
  input  logic                     over_limit,
  input  logic                     cfg_gpio_mode,
  input  logic                     gpio_dir,
  input  logic                     gpio_out,
  output logic                     gpio_in,
  input  logic                     clr_status_rd,
  input  logic                     clr_cfg_set,
  input  logic                     clr_alert_resp,
  output logic                     irq,
  input  logic [PWM_CH*PWM_W-1:0]  pwm_in,
  output logic [PWM_CH*PWM_W-1:0]  pwm_out,
  input  logic [DAC_CH*DAC_W-1:0]  dac_in,
  output logic [DAC_CH*DAC_W-1:0]  dac_out
);
  localparam int PWM_BITS = PWM_CH * PWM_W;
  localparam int DAC_BITS = DAC_CH * DAC_W;

  pin_role_e role;
  pad_drv_t  drv;
  logic      pad_lvl_s;   // synchronized pad level
  logic      pin_alarm;   // external low seen in alarm mode
  logic      thermal_evt; // any source of the interrupt

  assign role = cfg_gpio_mode ? ROLE_GPIO : ROLE_ALARM;
  assign drv  = pad_drive(role, over_limit, gpio_dir, gpio_out);
  assign pad_oe  = drv.oe;
  assign pad_out = drv.val;

  therm_sync #(.STAGES(SYNC_STG), .RESET_VAL(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pad_in), .q(pad_lvl_s)
  );

  assign gpio_in     = pad_lvl_s;
  assign pin_alarm   = (role == ROLE_ALARM) && !pad_lvl_s;
  assign thermal_evt = over_limit | pin_alarm;

  therm_irq u_irq (
    .clk(clk), .rst_n(rst_n), .evt(thermal_evt),
    .clr_status_rd(clr_status_rd), .clr_cfg_set(clr_cfg_set),
    .clr_alert_resp(clr_alert_resp), .irq(irq)
  );

  therm_force #(.CH(PWM_CH), .W(PWM_W)) u_pwm (
    .force_max(pin_alarm), .din(pwm_in), .dout(pwm_out)
  );

  therm_force #(.CH(DAC_CH), .W(DAC_W)) u_dac (
    .force_max(pin_alarm), .din(dac_in), .dout(dac_out)
  );

  a_r1_alarm_drive: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_gpio_mode |-> (pad_oe == over_limit && !pad_out));
  a_r2_gpio_drive: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_gpio_mode |-> (pad_oe == gpio_dir && pad_out == gpio_out));
  a_r3_force_full: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_gpio_mode && $past(rst_n) && $past(rst_n, 2) && !$past(pad_in, 2))
      |-> (pwm_out == {PWM_BITS{1'b1}} && dac_out == {DAC_BITS{1'b1}}));
  a_r4_release: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_gpio_mode && $past(rst_n) && $past(rst_n, 2) && $past(pad_in, 2))
      |-> (pwm_out == pwm_in && dac_out == dac_in));
  a_r5_gpio_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_gpio_mode |-> (pwm_out == pwm_in && dac_out == dac_in));
endmodule

// File: tb/tb_therm_ovr_ctrl.sv
`timescale 1ns/1ps
module tb_therm_ovr_ctrl;
  localparam int PWM_CH = 2, PWM_W = 8, DAC_CH = 1, DAC_W = 8;
  localparam logic [15:0] PWM_V = 16'h3CA5;
  localparam logic [7:0]  DAC_V = 8'h5A;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ext_lvl = 1'b1;
  logic pad_in, pad_oe, pad_out;
  logic over_limit = 1'b0, cfg_gpio_mode = 1'b0, gpio_dir = 1'b0, gpio_out = 1'b0;
  logic gpio_in, irq;
  logic clr_status_rd = 1'b0, clr_cfg_set = 1'b0, clr_alert_resp = 1'b0;
  logic [15:0] pwm_in = PWM_V, pwm_out;
  logic [7:0]  dac_in = DAC_V, dac_out;
  int errors = 0, checks = 0;
  bit done = 0;

  always #2 clk = ~clk;

  // Open-drain wired-AND pad.
  assign pad_in = ext_lvl & ~(pad_oe & ~pad_out);

  therm_ovr_ctrl #(.PWM_CH(PWM_CH), .PWM_W(PWM_W), .DAC_CH(DAC_CH), .DAC_W(DAC_W)) dut (
    .clk(clk), .rst_n(rst_n), .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out),
    .over_limit(over_limit), .cfg_gpio_mode(cfg_gpio_mode), .gpio_dir(gpio_dir),
    .gpio_out(gpio_out), .gpio_in(gpio_in), .clr_status_rd(clr_status_rd),
    .clr_cfg_set(clr_cfg_set), .clr_alert_resp(clr_alert_resp), .irq(irq),
    .pwm_in(pwm_in), .pwm_out(pwm_out), .dac_in(dac_in), .dac_out(dac_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_forced(input string req, input bit forced);
    chk(req, {8'h0, pwm_out, dac_out}, forced ? 32'h00FF_FFFF : {8'h0, PWM_V, DAC_V});
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // {mode, ext, ovl, dir, gout, exp_oe, exp_out, exp_force, exp_gin}
  localparam logic [8:0] VEC [0:7] = '{
    9'b0_1_0_0_0_0_0_0_1,  // alarm idle
    9'b0_0_0_0_0_0_0_1_0,  // external low forces
    9'b0_1_1_0_0_1_0_1_0,  // self-pulled low forces
    9'b1_0_0_0_0_0_0_0_0,  // GPIO: external low ignored
    9'b1_1_0_1_0_1_0_0_0,  // GPIO drives low, no force
    9'b1_1_0_1_1_1_1_0_1,  // GPIO drives high
    9'b1_1_1_0_0_0_0_0_1,  // GPIO: over_limit not on pad
    9'b0_1_0_1_1_0_0_0_1   // alarm: GPIO regs ignored
  };

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R10: reset state with pad held low
    ext_lvl = 1'b0;
    step(3);
    chk("R10 irq in reset", irq, 0);
    chk_forced("R10 no force in reset", 0);
    chk("R10 gpio_in in reset", gpio_in, 1);
    rst_n = 1'b1;
    ext_lvl = 1'b1;
    step(1);
    chk_forced("R10 no force after reset", 0);
    step(3);

    // Table walk: R1 R2 R3 R5 R11
    for (int v = 0; v < 8; v++) begin
      {cfg_gpio_mode, ext_lvl, over_limit, gpio_dir, gpio_out} = VEC[v][8:4];
      step(3);
      chk($sformatf("R1/R2 pad_oe vec%0d", v), pad_oe, VEC[v][3]);
      chk($sformatf("R1/R2 pad_out vec%0d", v), pad_out, VEC[v][2]);
      chk_forced($sformatf("R3/R5 force vec%0d", v), VEC[v][1]);
      chk($sformatf("R11 gpio_in vec%0d", v), gpio_in, VEC[v][0]);
    end
    {cfg_gpio_mode, ext_lvl, over_limit, gpio_dir, gpio_out} = 5'b01000;
    step(4);
    clr_status_rd = 1; step(1); clr_status_rd = 0; step(1);
    chk("R8 idle after clear", irq, 0);

    // R3/R4 timing
    ext_lvl = 1'b0;
    step(1); chk_forced("R3 not forced after one edge", 0);
    step(1); chk_forced("R3 forced after two edges", 1);
    ext_lvl = 1'b1;
    step(1); chk_forced("R4 still forced one edge after release", 1);
    step(1); chk_forced("R4 released two edges after release", 0);

    // R6/R7/R8 with each clear source
    for (int s = 0; s < 3; s++) begin
      clr_status_rd = 1; step(1); clr_status_rd = 0;
      over_limit = 1'b1;
      step(1); chk($sformatf("R6 irq set src%0d", s), irq, 1);
      over_limit = 1'b0;
      step(4); chk($sformatf("R7 irq sticky src%0d", s), irq, 1);
      case (s)
        0: clr_status_rd = 1;
        1: clr_cfg_set = 1;
        default: clr_alert_resp = 1;
      endcase
      step(1);
      {clr_status_rd, clr_cfg_set, clr_alert_resp} = 3'b000;
      chk($sformatf("R8 clear src%0d", s), irq, 0);
      step(2); chk($sformatf("R8 stays clear src%0d", s), irq, 0);
    end

    // R9: clear while condition persists
    ext_lvl = 1'b0;
    step(3);
    chk("R9 irq from pad low", irq, 1);
    clr_alert_resp = 1; step(1); clr_alert_resp = 0;
    chk("R9 cleared for one cycle", irq, 0);
    step(1); chk("R9 set again", irq, 1);
    ext_lvl = 1'b1;
    step(3);

    // R5: GPIO mode pad low raises no irq
    cfg_gpio_mode = 1'b1;
    clr_cfg_set = 1; step(1); clr_cfg_set = 0;
    ext_lvl = 1'b0;
    step(4);
    chk("R5 no irq from pad in GPIO", irq, 0);
    chk_forced("R5 no force in GPIO", 0);
    chk("R11 gpio_in low in GPIO", gpio_in, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule